// File: doc/BRIEF.md
# Load-Speculative Issue Abort Tracker

This block follows the instructions an issue stage sends out while a load's data is still unconfirmed. Each load is followed by a short speculative window. An instruction issued from the matching queue inside that window is held by the tracker until the data cache reports hit or miss for the load. The tracker then either deletes the instruction from its issue queue or aborts it, so that it may request issue again. Instructions issued outside any window are deleted after the normal fixed delay.

The two queues follow different rules. On an integer miss, every integer instruction in the window is aborted, whether or not it depends on the load. On a floating-point miss, only the instructions that use the load's result are aborted. A load whose destination is the zero register produces nothing and opens no window. A mode input can turn off the integer window, so integer loads then open none.

Timing is counted in load ages. The cycle in which a load issues is age 0, and the hit/miss result is presented at age 4. Instructions carry an identifier chosen by the issuer. Each output is a mask with one bit per identifier.

Top module: `lsa_tracker`

## Requirements
- R1: After reset, both `del_mask` and `abort_mask` are all zero.
- R2: An instruction issued at cycle s that falls in no open window of its own queue gets its `del_mask` bit in cycle s+3, and no abort.
- R3: With the integer window enabled, an integer load with a non-zero destination opens a window covering ages 2 and 3. On a hit, an integer instruction issued at age 2 or at age 3 is deleted at age 6. For the age 2 instruction this is one cycle later than normal.
- R4: When an integer window load misses (`res_valid` and `res_miss` high at age 4), every integer instruction issued in its window gets its `abort_mask` bit at age 5, independent of `iss_dep`. It is never deleted.
- R5: A floating-point load's window is age 3 only. A floating-point instruction issued at age 2 or at age 4 of that load is treated as in R2.
- R6: When a floating-point load misses, a floating-point instruction in its window with `iss_dep`=1 is aborted at age 5. One with `iss_dep`=0 is deleted at age 6, its normal time.
- R7: When a floating-point load hits, every floating-point instruction in its window is deleted at age 6.
- R8: A load whose destination register is 31 (all ones in `ld_dst`) opens no window. Instructions near it behave as in R2, even when the load misses.
- R9: With `int_spec_en`=0 at the load's issue cycle, an integer load opens no window. A miss on that load aborts nothing.
- R10: A window only holds instructions of its own queue. A floating-point instruction in an integer load's window, or an integer instruction in a floating-point load's window, is handled as in R2.
- R11: Each issued instruction gets exactly one strobe: a single delete or a single abort, never both and never repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| int_spec_en | input | 1 | Enables the integer speculative window, sampled with each load |
| ld_valid | input | 1 | A load issues this cycle |
| ld_fp | input | 1 | The issuing load is floating-point (1) or integer (0) |
| ld_dst | input | REG_W | Destination register of the load; all ones is the zero register |
| iss_valid | input | 1 | A non-load instruction issues this cycle |
| iss_fp | input | 1 | The instruction comes from the floating-point queue (1) or the integer queue (0) |
| iss_dep | input | 1 | The instruction consumes the result of the load whose window it is in |
| iss_id | input | ID_W | Identifier of the issuing instruction |
| res_valid | input | 1 | Cache result present for the load now at age 4 |
| res_miss | input | 1 | The load at age 4 missed |
| del_mask | output | NUM_ID | One bit per identifier: delete this instruction from its queue now |
| abort_mask | output | NUM_ID | One bit per identifier: abort this instruction; it may request issue again |

## Verification
The assertions assume that the cache result arrives exactly at age 4 of every load and at no other time. They also assume that two windows of the same queue never overlap and that an identifier is not reused while its instruction is still waiting. The bench keeps to these rules by running one load per scenario. It issues a single instruction at a chosen age and drives the result only at age 4. It then drains the pipeline fully before the next scenario starts.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  // load ages, counted from the load's issue cycle (age 0)
  localparam int INT_WIN_FIRST = 2;
  localparam int INT_WIN_LAST  = 3;
  localparam int FP_WIN_AGE    = 3;
  localparam int RESULT_AGE    = 4;
  localparam int DELETE_AGE    = 6;
  // issue-to-delete delay for an instruction outside any window
  localparam int NORMAL_DELAY  = 3;

  function automatic logic age_in_window(input logic is_fp, input int age);
    if (is_fp) return age == FP_WIN_AGE;
    return (age >= INT_WIN_FIRST) && (age <= INT_WIN_LAST);
  endfunction
endpackage

// File: rtl/lsa_load_pipe.sv
module lsa_load_pipe
  import lsa_pkg::*;
#(
  parameter int NUM_ID = 8,
  parameter int REG_W  = 5,
  parameter int ID_W   = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_spec_en,
  input  logic              ld_valid,
  input  logic              ld_fp,
  input  logic [REG_W-1:0]  ld_dst,
  input  logic              iss_valid,
  input  logic              iss_fp,
  input  logic              iss_dep,
  input  logic [ID_W-1:0]   iss_id,
  output logic              capture,
  output logic              res_ld,
  output logic              res_fp,
  output logic              res_spec,
  output logic [NUM_ID-1:0] res_members,
  output logic [NUM_ID-1:0] res_deps
);
  localparam logic [REG_W-1:0] ZERO_REG = '1;

  logic              st_ld   [1:RESULT_AGE];
  logic              st_fp   [1:RESULT_AGE];
  logic              st_spec [1:RESULT_AGE];
  logic [NUM_ID-1:0] st_mem  [1:RESULT_AGE];
  logic [NUM_ID-1:0] st_dep  [1:RESULT_AGE];
  logic              win_hit [1:RESULT_AGE];

  logic [NUM_ID-1:0] iss_bit;
  logic              opens_window;

  assign iss_bit      = NUM_ID'(1) << iss_id;
  assign opens_window = ld_valid && (ld_dst != ZERO_REG) && (ld_fp || int_spec_en);

  // an issuing instruction joins each open window of its own queue
  always_comb begin
    capture = 1'b0;
    for (int k = 1; k <= RESULT_AGE; k++) begin
      win_hit[k] = st_spec[k] && iss_valid && (iss_fp == st_fp[k])
                   && age_in_window(st_fp[k], k);
      capture    = capture | win_hit[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k <= RESULT_AGE; k++) begin
        st_ld[k]   <= 1'b0;
        st_fp[k]   <= 1'b0;
        st_spec[k] <= 1'b0;
        st_mem[k]  <= '0;
        st_dep[k]  <= '0;
      end
    end else begin
      st_ld[1]   <= ld_valid;
      st_fp[1]   <= ld_fp;
      st_spec[1] <= opens_window;
      st_mem[1]  <= '0;
      st_dep[1]  <= '0;
      for (int k = 2; k <= RESULT_AGE; k++) begin
        st_ld[k]   <= st_ld[k-1];
        st_fp[k]   <= st_fp[k-1];
        st_spec[k] <= st_spec[k-1];
        st_mem[k]  <= st_mem[k-1] | (win_hit[k-1] ? iss_bit : '0);
        st_dep[k]  <= st_dep[k-1] | ((win_hit[k-1] && iss_dep) ? iss_bit : '0);
      end
    end
  end

  assign res_ld      = st_ld[RESULT_AGE];
  assign res_fp      = st_fp[RESULT_AGE];
  assign res_spec    = st_spec[RESULT_AGE];
  assign res_members = st_mem[RESULT_AGE];
  assign res_deps    = st_dep[RESULT_AGE];

  a_r8_zero_dst_no_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_dst == ZERO_REG) |=> !st_spec[1]);

  a_r9_int_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_fp && !int_spec_en) |=> !st_spec[1]);

  a_r5_fp_window_age: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && iss_fp) |-> (st_spec[FP_WIN_AGE] && st_fp[FP_WIN_AGE]));

  a_r10_queue_match: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !iss_fp) |-> ((st_spec[INT_WIN_FIRST] && !st_fp[INT_WIN_FIRST])
                             || (st_spec[INT_WIN_LAST] && !st_fp[INT_WIN_LAST])));
endmodule

// File: rtl/lsa_resolve.sv
module lsa_resolve
  import lsa_pkg::*;
#(
  parameter int NUM_ID = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic              res_miss,
  input  logic              res_fp,
  input  logic              res_spec,
  input  logic [NUM_ID-1:0] members,
  input  logic [NUM_ID-1:0] deps,
  output logic [NUM_ID-1:0] abort_mask,
  output logic [NUM_ID-1:0] keep_mask
);
  localparam int KEEP_LAT = DELETE_AGE - RESULT_AGE;

  function automatic logic [NUM_ID-1:0] pick_aborts(input logic missed, input logic is_fp,
                                                    input logic [NUM_ID-1:0] mem,
                                                    input logic [NUM_ID-1:0] dep);
    if (!missed) return '0;
    return is_fp ? (mem & dep) : mem;
  endfunction

  logic [NUM_ID-1:0] abort_now;
  logic [NUM_ID-1:0] abort_q;
  logic [NUM_ID-1:0] keep_q [1:KEEP_LAT];

  assign abort_now = pick_aborts(res_valid && res_miss && res_spec, res_fp, members, deps);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_q <= '0;
      for (int k = 1; k <= KEEP_LAT; k++) keep_q[k] <= '0;
    end else begin
      abort_q   <= abort_now;
      keep_q[1] <= members & ~abort_now;
      for (int k = 2; k <= KEEP_LAT; k++) keep_q[k] <= keep_q[k-1];
    end
  end

  assign abort_mask = abort_q;
  assign keep_mask  = keep_q[KEEP_LAT];

  a_r4_abort_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_mask) |-> $past(res_valid && res_miss));

  a_r6_fp_abort_dependent: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fp) |=> ((abort_mask & ~$past(deps)) == '0));
endmodule

// File: rtl/lsa_plain_pipe.sv
module lsa_plain_pipe
  import lsa_pkg::*;
#(
  parameter int NUM_ID = 8,
  parameter int ID_W   = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  output logic [NUM_ID-1:0] del_mask
);
  logic            v_q  [1:NORMAL_DELAY];
  logic [ID_W-1:0] id_q [1:NORMAL_DELAY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 1; k <= NORMAL_DELAY; k++) begin
        v_q[k]  <= 1'b0;
        id_q[k] <= '0;
      end
    end else begin
      v_q[1]  <= in_valid;
      id_q[1] <= in_id;
      for (int k = 2; k <= NORMAL_DELAY; k++) begin
        v_q[k]  <= v_q[k-1];
        id_q[k] <= id_q[k-1];
      end
    end
  end

  for (genvar g = 0; g < NUM_ID; g++) begin : g_onehot
    assign del_mask[g] = v_q[NORMAL_DELAY] && (id_q[NORMAL_DELAY] == ID_W'(g));
  end
endmodule

// File: rtl/lsa_tracker.sv
module lsa_tracker
  import lsa_pkg::*;
#(
  parameter int NUM_ID = 8,
  parameter int REG_W  = 5,
  parameter int ID_W   = $clog2(NUM_ID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_spec_en,
  input  logic              ld_valid,
  input  logic              ld_fp,
  input  logic [REG_W-1:0]  ld_dst,
  input  logic              iss_valid,
  input  logic              iss_fp,
  input  logic              iss_dep,
  input  logic [ID_W-1:0]   iss_id,
  input  logic              res_valid,
  input  logic              res_miss,
  output logic [NUM_ID-1:0] del_mask,
  output logic [NUM_ID-1:0] abort_mask
);
  logic              capture;
  logic              res_ld;
  logic              res_fp;
  logic              res_spec;
  logic [NUM_ID-1:0] res_members;
  logic [NUM_ID-1:0] res_deps;
  logic [NUM_ID-1:0] keep_mask;
  logic [NUM_ID-1:0] plain_mask;
  logic              plain_valid;

  assign plain_valid = iss_valid && !capture;

  lsa_load_pipe #(.NUM_ID(NUM_ID), .REG_W(REG_W), .ID_W(ID_W)) u_load_pipe (
    .clk(clk), .rst_n(rst_n), .int_spec_en(int_spec_en),
    .ld_valid(ld_valid), .ld_fp(ld_fp), .ld_dst(ld_dst),
    .iss_valid(iss_valid), .iss_fp(iss_fp), .iss_dep(iss_dep), .iss_id(iss_id),
    .capture(capture), .res_ld(res_ld), .res_fp(res_fp), .res_spec(res_spec),
    .res_members(res_members), .res_deps(res_deps)
  );

  lsa_resolve #(.NUM_ID(NUM_ID)) u_resolve (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_miss(res_miss),
    .res_fp(res_fp), .res_spec(res_spec), .members(res_members), .deps(res_deps),
    .abort_mask(abort_mask), .keep_mask(keep_mask)
  );

  lsa_plain_pipe #(.NUM_ID(NUM_ID), .ID_W(ID_W)) u_plain (
    .clk(clk), .rst_n(rst_n), .in_valid(plain_valid), .in_id(iss_id),
    .del_mask(plain_mask)
  );

  assign del_mask = plain_mask | keep_mask;

  a_r11_one_strobe_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (del_mask & abort_mask) == '0);

  a_r11_no_merge_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_mask & keep_mask) == '0);

  a_r4_result_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == res_ld);

  a_r2_plain_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(plain_valid, NORMAL_DELAY) |->
      (((del_mask >> $past(iss_id, NORMAL_DELAY)) & NUM_ID'(1)) != '0));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (del_mask == '0 && abort_mask == '0));
endmodule

// File: tb/test_lsa_tracker.sv
module test_lsa_tracker;
  localparam int NUM_ID = 8;
  localparam int REG_W  = 5;
  localparam int ID_W   = 3;
  localparam logic [ID_W-1:0] CASE_ID = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic int_spec_en = 1'b0, ld_valid = 1'b0, ld_fp = 1'b0;
  logic [REG_W-1:0] ld_dst = '0;
  logic iss_valid = 1'b0, iss_fp = 1'b0, iss_dep = 1'b0;
  logic [ID_W-1:0] iss_id = '0;
  logic res_valid = 1'b0, res_miss = 1'b0;
  logic [NUM_ID-1:0] del_mask, abort_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsa_tracker #(.NUM_ID(NUM_ID), .REG_W(REG_W), .ID_W(ID_W)) i_lsa_tracker (
    .clk(clk), .rst_n(rst_n), .int_spec_en(int_spec_en), .ld_valid(ld_valid),
    .ld_fp(ld_fp), .ld_dst(ld_dst), .iss_valid(iss_valid), .iss_fp(iss_fp),
    .iss_dep(iss_dep), .iss_id(iss_id), .res_valid(res_valid), .res_miss(res_miss),
    .del_mask(del_mask), .abort_mask(abort_mask)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one load at age 0, one instruction at age o, result at age 4
  task automatic run_case(input logic lfp, input logic miss, input logic [REG_W-1:0] dst,
                          input logic mode, input logic ifp, input int o, input logic dep);
    int del_at, ab_at, strobes, e_del, e_ab;
    string tag;
    logic spec, in_win;
    spec   = (dst != 5'd31) && (lfp || mode);
    in_win = spec && (ifp == lfp) && (lfp ? (o == 3) : (o == 2 || o == 3));
    if (!in_win) begin
      e_del = o + 3; e_ab = -1;
    end else if (miss && (!lfp || dep)) begin
      e_del = -1; e_ab = 5;
    end else begin
      e_del = 6; e_ab = -1;
    end
    if (dst == 5'd31)          tag = "R8";
    else if (!spec)            tag = "R9";
    else if (ifp != lfp)       tag = "R10";
    else if (!in_win)          tag = lfp ? "R5" : "R2";
    else if (!lfp)             tag = miss ? "R4" : "R3";
    else                       tag = miss ? "R6" : "R7";

    del_at = -1; ab_at = -1; strobes = 0;
    for (int a = 0; a < 12; a++) begin
      if (a > 0) begin
        if (del_mask[CASE_ID] && del_at < 0) del_at = a;
        if (abort_mask[CASE_ID] && ab_at < 0) ab_at = a;
        strobes += $countones(del_mask) + $countones(abort_mask);
      end
      int_spec_en = mode;
      ld_valid    = (a == 0);
      ld_fp       = lfp;
      ld_dst      = dst;
      iss_valid   = (a == o);
      iss_fp      = ifp;
      iss_dep     = dep;
      iss_id      = CASE_ID;
      res_valid   = (a == 4);
      res_miss    = miss && (a == 4);
      @(posedge clk);
      @(negedge clk);
    end
    check(tag, "delete age", del_at, e_del);
    check(tag, "abort age", ab_at, e_ab);
    check("R11", "strobe count", strobes, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "del_mask", int'(del_mask), 0);
    check("R1", "abort_mask", int'(abort_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "del_mask after release", int'(del_mask), 0);
    check("R1", "abort_mask after release", int'(abort_mask), 0);
    for (int lq = 0; lq < 2; lq++)
      for (int ms = 0; ms < 2; ms++)
        for (int z = 0; z < 2; z++)
          for (int md = 0; md < 2; md++)
            for (int iq = 0; iq < 2; iq++)
              for (int o = 1; o <= 4; o++)
                for (int dp = 0; dp < 2; dp++)
                  run_case(lq[0], ms[0], z ? 5'd31 : 5'd7, md[0], iq[0], o, dp[0]);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule